// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 256K bytes. The host hands it one word at a time over a request/ready handshake. The block turns each request into a read or write cycle on the RAM pins. It drives the address, a pair of chip selects of opposite polarity, an active-low output enable, an active-low write enable and the enable for the data pad. The data pad is split into an outgoing value, an incoming value and a drive enable, so the chip-level pad cell forms the shared bidirectional bus.

Each analogue timing limit of the RAM is turned into a whole number of clock cycles at elaboration. The conversion rounds up and never gives less than one cycle, and uses a clock-period parameter and a speed-grade parameter (0, 1 or 2 for the 45, 55 and 70 ns parts). These limits are strobe widths, cycle times, data setup and the windows in which the RAM may still drive the bus. A write that follows a read waits longer before it drives the bus, because the RAM may still be driving it after the read.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and when no access is in progress, ready is 1, cs1_n is 1, cs2 is 0, oe_n is 1, we_n is 1 and dq_oe is 0.
- R2: The RAM is selected (cs1_n = 0 and cs2 = 1) in exactly the cycles in which ready is 0. In every other cycle cs1_n = 1 and cs2 = 0.
- R3: A read holds oe_n = 0, we_n = 1 and dq_oe = 0 for all its busy cycles. The number of busy cycles is RD = ceil(max(read cycle, access time) / CLK_NS). For grade 0 at 8 ns this is 6.
- R4: Read data is taken from dq_in on the edge that ends the output-enable window. It shows on rdata when ready returns to 1, and rdata changes at no other time.
- R5: A write pulls we_n to 0 from its first busy cycle for WL = max(ceil(tWP), DS + ceil(tDW)) cycles, and oe_n stays 1 throughout.
- R6: The data pad is enabled DS cycles after we_n falls. DS = ceil(tWHZ), or max(ceil(tWHZ), ceil(bus release)) when the previous access was a read. For grade 0 at 8 ns, DS is 2 normally and 3 after a read.
- R7: The data pad stays enabled, with the write data on dq_out, from cycle DS through the one cycle after we_n rises (cycle WL). It is disabled after that.
- R8: A write keeps ready at 0 for max(ceil(tWC), WL + 1) cycles. For grade 0 at 8 ns this is 7 normally and 8 after a read.
- R9: A request is taken only on an edge where ready is 1. A req raised while busy is ignored: sram_addr holds the accepted address for the whole access, and no write strobe or data change results.
- R10: sram_addr carries the accepted 18-bit address for every busy cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, taken when ready is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Captured read data |
| ready | output | 1 | Idle and able to accept a request |
| sram_addr | output | 18 | RAM address pins |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| dq_out | output | 8 | Value for the data pad |
| dq_oe | output | 1 | Data pad drive enable |
| dq_in | input | 8 | Value seen on the data pad |

## Verification
Some properties are checked by assertions on every cycle. The data pad is never enabled in a read or in the first cycle of a write strobe. The write data is driven in the cycle before we_n rises. The address holds while a request arrives during a busy cycle. rdata moves only on a read's final edge. Other behaviour only the bench scenarios can show: the exact cycle counts of each strobe window, the longer turnaround after a read, and that a written byte comes back on a later read. The bench shows these by measuring each window at the pins and comparing against its own table of timings.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Round a nanosecond limit up to whole clocks, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // Grade 0/1/2 = 45/55/70 ns parts.
  function automatic int t_cycle(input int g);
    return (g == 0) ? 45 : (g == 1) ? 55 : 70;
  endfunction
  function automatic int t_wpulse(input int g);
    return (g == 0) ? 35 : (g == 1) ? 40 : 50;
  endfunction
  function automatic int t_dsetup(input int g);
    return (g == 2) ? 30 : 25;
  endfunction
  function automatic int t_we_float(input int g);
    return (g == 0) ? 15 : 20;
  endfunction
  function automatic int t_release(input int g);
    return (g == 2) ? 25 : 20;
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int GRADE  = 0,
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              cs_act,
  output logic              oe_act,
  output logic              we_act,
  output logic              drv_en,
  output logic [DATA_W-1:0] dq_out,
  output logic              rd_done
);

  localparam int RD_C  = ns_to_cyc(t_cycle(GRADE), CLK_NS);
  localparam int WC_C  = ns_to_cyc(t_cycle(GRADE), CLK_NS);
  localparam int WP_C  = ns_to_cyc(t_wpulse(GRADE), CLK_NS);
  localparam int DW_C  = ns_to_cyc(t_dsetup(GRADE), CLK_NS);
  localparam int WHZ_C = ns_to_cyc(t_we_float(GRADE), CLK_NS);
  localparam int HZ_C  = ns_to_cyc(t_release(GRADE), CLK_NS);
  localparam int DS_N  = WHZ_C;
  localparam int DS_T  = imax(WHZ_C, HZ_C);
  localparam int WL_N  = imax(WP_C, DS_N + DW_C);
  localparam int WL_T  = imax(WP_C, DS_T + DW_C);
  localparam int WT_N  = imax(WC_C, WL_N + 1);
  localparam int WT_T  = imax(WC_C, WL_T + 1);
  localparam int MAXC  = imax(RD_C, WT_T);
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last_rd_q;
  logic              turn_q;

  logic              accept;
  logic              wr_done;
  logic [CNT_W-1:0]  ds, wl, wt_end;

  assign accept  = (state_q == ST_IDLE) && req;
  assign ds      = turn_q ? CNT_W'(DS_T) : CNT_W'(DS_N);
  assign wl      = turn_q ? CNT_W'(WL_T) : CNT_W'(WL_N);
  assign wt_end  = turn_q ? CNT_W'(WT_T - 1) : CNT_W'(WT_N - 1);
  assign rd_done = (state_q == ST_READ) && (cnt_q == CNT_W'(RD_C - 1));
  assign wr_done = (state_q == ST_WRITE) && (cnt_q == wt_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      last_rd_q <= 1'b0;
      turn_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= we ? ST_WRITE : ST_READ;
          cnt_q   <= '0;
          addr_q  <= addr;
          wdata_q <= wdata;
          turn_q  <= we && last_rd_q;
        end
        ST_READ: begin
          cnt_q <= cnt_q + 1'b1;
          if (rd_done) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b1;
          end
        end
        ST_WRITE: begin
          cnt_q <= cnt_q + 1'b1;
          if (wr_done) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready     = (state_q == ST_IDLE);
  assign cs_act    = (state_q != ST_IDLE);
  assign oe_act    = (state_q == ST_READ);
  assign we_act    = (state_q == ST_WRITE) && (cnt_q < wl);
  assign drv_en    = (state_q == ST_WRITE) && (cnt_q >= ds) && (cnt_q <= wl);
  assign sram_addr = addr_q;
  assign dq_out    = wdata_q;

  // R3
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_act |-> !drv_en && !we_act);

  // R6
  strobe_first_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_act) |-> !drv_en);

  // R7
  setup_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_act) |-> drv_en && $past(drv_en));

  // R9
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && req && !rd_done && !wr_done) |=> $stable(sram_addr) && !ready);

endmodule

// File: rtl/sram_rdata_reg.sv
module sram_rdata_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n)   dout <= '0;
    else if (cap) dout <= din;
  end

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(dout));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_NS = 8,
  parameter int GRADE  = 0,
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  logic cs_act, oe_act, we_act, drv_en, rd_done;

  sram_seq #(
    .CLK_NS(CLK_NS), .GRADE(GRADE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .sram_addr(sram_addr), .cs_act(cs_act), .oe_act(oe_act),
    .we_act(we_act), .drv_en(drv_en), .dq_out(dq_out), .rd_done(rd_done)
  );

  sram_rdata_reg #(.DATA_W(DATA_W)) u_rdata (
    .clk(clk), .rst_n(rst_n), .cap(rd_done), .din(dq_in), .dout(rdata)
  );

  assign sram_cs1_n = ~cs_act;
  assign sram_cs2   = cs_act;
  assign sram_oe_n  = ~oe_act;
  assign sram_we_n  = ~we_act;
  assign dq_oe      = drv_en;

  // R5
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  // R4
  capture_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> ready && sram_oe_n);

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int GRADE = 0;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we_i = 1'b0;
  logic [17:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata, dq_out, dq_in;
  logic        ready, cs1_n, cs2, oe_n, we_n, dq_oe;
  logic [17:0] sram_addr;

  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];
  int n_chk = 0, n_fail = 0;
  bit prev_rd = 1'b0;

  always #4 clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS), .GRADE(GRADE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we_i), .addr(addr_i),
    .wdata(wdata_i), .rdata(rdata), .ready(ready), .sram_addr(sram_addr),
    .sram_cs1_n(cs1_n), .sram_cs2(cs2), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // Behavioural RAM: low address bits only, aliasing is consistent.
  wire sel = !cs1_n && cs2;
  assign dq_in = (sel && !oe_n && we_n) ? mem[sram_addr[9:0]] : 8'h00;
  always @(posedge clk) if (sel && !we_n && dq_oe) mem[sram_addr[9:0]] <= dq_out;

  function automatic int cyc(input int ns);
    int c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction
  function automatic int e_rd();  return cyc(GRADE == 0 ? 45 : GRADE == 1 ? 55 : 70); endfunction
  function automatic int e_ds(input bit t);
    int whz = cyc(GRADE == 0 ? 15 : 20);
    int hz  = cyc(GRADE == 2 ? 25 : 20);
    return t ? mx(whz, hz) : whz;
  endfunction
  function automatic int e_wl(input bit t);
    return mx(cyc(GRADE == 0 ? 35 : GRADE == 1 ? 40 : 50), e_ds(t) + cyc(GRADE == 2 ? 30 : 25));
  endfunction
  function automatic int e_wt(input bit t); return mx(e_rd(), e_wl(t) + 1); endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    check(ready && cs1_n && !cs2 && oe_n && we_n && !dq_oe, tag,
          {ready, cs1_n, cs2, oe_n, we_n, dq_oe}, 6'b110110);
  endtask

  // One access; intrude=1 raises a stray write request mid-read (R9).
  task automatic run_txn(input bit w, input logic [17:0] a, input logic [7:0] d,
                         input bit intrude);
    int busy = 0, we_lo = 0, oe_lo = 0, first_drv = -1, last_drv = -1;
    bit bad_addr = 0, bad_cs = 0, bad_data = 0, t;
    t = w && prev_rd;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    req = 1'b0;
    while (!ready) begin
      if (intrude && busy == 2) begin req = 1'b1; we_i = 1'b1; addr_i = a ^ 18'h155; wdata_i = ~d; end
      if (intrude && busy == 3) req = 1'b0;
      if (sram_addr != a) bad_addr = 1;
      if (cs1_n || !cs2) bad_cs = 1;
      if (!we_n) we_lo++;
      if (!oe_n) oe_lo++;
      if (dq_oe) begin
        if (first_drv < 0) first_drv = busy;
        last_drv = busy;
        if (dq_out != d) bad_data = 1;
      end
      busy++;
      @(negedge clk);
    end
    check(!bad_addr, intrude ? "R9 addr held under stray req" : "R10 address", int'(bad_addr), 0);
    check(!bad_cs, "R2 select during busy", int'(bad_cs), 0);
    check_idle("R1 idle after access");
    if (!w) begin
      check(busy == e_rd(), "R3 read length", busy, e_rd());
      check(oe_lo == busy && we_lo == 0 && first_drv < 0, "R3 read strobes",
            oe_lo * 100 + we_lo, busy * 100);
      check(rdata == exp_mem[a[9:0]], "R4 read data", rdata, exp_mem[a[9:0]]);
      if (intrude) check(we_lo == 0, "R9 no write strobe", we_lo, 0);
      prev_rd = 1'b1;
    end else begin
      check(we_lo == e_wl(t) && oe_lo == 0, "R5 write strobe", we_lo, e_wl(t));
      check(first_drv == e_ds(t), t ? "R6 drive start after read" : "R6 drive start",
            first_drv, e_ds(t));
      check(last_drv == e_wl(t) && !bad_data, "R7 drive end/data", last_drv, e_wl(t));
      check(busy == e_wt(t), "R8 write length", busy, e_wt(t));
      exp_mem[a[9:0]] = d;
      prev_rd = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    // Directed corners
    run_txn(1'b1, 18'h00000, 8'hFF, 1'b0);
    run_txn(1'b1, 18'h3FFFF, 8'h00, 1'b0);
    run_txn(1'b0, 18'h00000, 8'h00, 1'b0);
    run_txn(1'b1, 18'h3FFFF, 8'hA5, 1'b0);   // write after read: turnaround
    run_txn(1'b0, 18'h3FFFF, 8'h00, 1'b0);
    run_txn(1'b0, 18'h00000, 8'h00, 1'b1);   // stray request during read
    run_txn(1'b0, 18'h00000 ^ 18'h155, 8'h00, 1'b0);
    // Constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [17:0] a;
      a = 18'($urandom) & 18'h3F0FF;
      if ($urandom_range(1, 0) == 1) run_txn(1'b1, a, 8'($urandom), 1'b0);
      else run_txn(1'b0, a, 8'h00, 1'b0);
      repeat ($urandom_range(2, 0)) @(negedge clk);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule